// File: doc/BRIEF.md
# Privileged control register unit

This block keeps the privileged control state of a 32-bit register-window RISC core: a status word (current window pointer, trap enable, supervisor and previous-supervisor bits, interrupt level, FPU and coprocessor enables, and a constant implementation/version byte), a window invalid mask and a trap base register. It also keeps a small bank of ancillary state registers that any mode may access. The pipeline presents one operation per cycle: a register read or write, plus two operands, an immediate flag and a 13-bit immediate.

Every write stores the exclusive-OR of the first operand and a second operand. The second operand is either the second register value or the sign-extended immediate. Read data is registered and appears one cycle after the read. The status fields drive the pipeline directly. Two trap-request pulses report a privilege violation or an illegal status write. The trap-type byte inside the trap base register is loaded by the trap hardware through a separate strobe. Software writes never touch it.

Top module: `priv_ctl_regs`

## Requirements
- R1: A write stores src1 XOR op2. When use_imm=0, op2 is src2. When use_imm=1, op2 is imm13 sign-extended from bit 12 to 32 bits.
- R2: Operation codes are 1 status read, 2 status write, 3 mask read, 4 mask write, 5 trap-base read, 6 trap-base write, 7 ancillary read and 8 ancillary write. All other codes do nothing. A granted read puts the register value on rd_data one cycle later. rd_data holds its value through every cycle that has no granted read.
- R3: A mask read returns the stored 32-bit mask ANDed with (1<<NWIN)-1, so bits for windows that do not exist read as zero.
- R4: The trap-base word reads as {base[31:12], tt[11:4], 4'b0}. A trap-base write changes only base, taken from the written value's bits 31:12. A pulse on tt_load sets tt to tt_code, and a write in the same cycle leaves that load intact.
- R5: The status word reads as {IMPL_VER[31:24], 10'b0, cop_en[13], fpu_en[12], irq_level[11:8], sup[7], prev_sup[6], trap_en[5], cwp[4:0]}. A status write updates every field except bits 31:14, which are constant.
- R6: A status write whose written bits 4:0 are at least NWIN changes nothing and raises trap_illegal for one cycle, one cycle after the write. cwp is always below NWIN.
- R7: Any of operations 1 to 6 issued with priv_mode=0 changes no register and leaves rd_data unchanged. It raises trap_priv for one cycle, one cycle after the operation.
- R8: After reset, sup=1, trap_en=0, cwp=0, prev_sup=0, irq_level=0, fpu_en=0, cop_en=0, and the mask, trap base, trap type, ancillary registers and rd_data are all zero.
- R9: Operations 7 and 8 reach the ancillary register selected by anc_sel, in either privilege mode, and never raise a trap.
- R10: The status outputs show the new field values one cycle after a legal status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation code (R2) |
| anc_sel | input | ANC_AW | Ancillary register index |
| src1 | input | 32 | First operand |
| src2 | input | 32 | Second register operand |
| use_imm | input | 1 | Selects the immediate as the second operand |
| imm13 | input | 13 | Signed immediate |
| priv_mode | input | 1 | Supervisor-mode indication from the pipeline |
| tt_load | input | 1 | Hardware load strobe for the trap-type byte |
| tt_code | input | 8 | Trap-type value to load |
| rd_data | output | 32 | Registered read data |
| cwp | output | 5 | Current window pointer |
| sup | output | 1 | Supervisor bit |
| prev_sup | output | 1 | Previous-supervisor bit |
| trap_en | output | 1 | Trap enable |
| irq_level | output | 4 | Processor interrupt level |
| fpu_en | output | 1 | FPU enable |
| cop_en | output | 1 | Coprocessor enable |
| trap_priv | output | 1 | Privilege-violation trap request pulse |
| trap_illegal | output | 1 | Illegal status-write trap request pulse |

## Verification
Every result of this block comes one register after its operation: read data, the status field outputs and both trap pulses are all due at the clock edge that captures the operation. The bench applies each operation just after a falling edge and removes it at the next falling edge. It compares all outputs at that falling edge, half a cycle after the capturing edge, before any later operation can reach them. For effects that leave no output in that cycle, such as an ignored write, the bench follows up with a read and checks the returned value on the next falling edge in the same way.

// File: rtl/priv_ctl_regs.sv
module priv_ctl_regs #(
  parameter int NWIN = 8,
  parameter int ANC_AW = 2,
  parameter logic [7:0] IMPL_VER = 8'h1A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op,
  input  logic [ANC_AW-1:0] anc_sel,
  input  logic [31:0]       src1,
  input  logic [31:0]       src2,
  input  logic              use_imm,
  input  logic [12:0]       imm13,
  input  logic              priv_mode,
  input  logic              tt_load,
  input  logic [7:0]        tt_code,
  output logic [31:0]       rd_data,
  output logic [4:0]        cwp,
  output logic              sup,
  output logic              prev_sup,
  output logic              trap_en,
  output logic [3:0]        irq_level,
  output logic              fpu_en,
  output logic              cop_en,
  output logic              trap_priv,
  output logic              trap_illegal
);

  localparam int NANC = 1 << ANC_AW;
  localparam logic [31:0] WMASK = (NWIN >= 32) ? 32'hFFFF_FFFF : ((32'd1 << NWIN) - 32'd1);

  localparam logic [3:0] OP_RD_STAT = 4'd1;
  localparam logic [3:0] OP_WR_STAT = 4'd2;
  localparam logic [3:0] OP_RD_MASK = 4'd3;
  localparam logic [3:0] OP_WR_MASK = 4'd4;
  localparam logic [3:0] OP_RD_TB   = 4'd5;
  localparam logic [3:0] OP_WR_TB   = 4'd6;
  localparam logic [3:0] OP_RD_ANC  = 4'd7;
  localparam logic [3:0] OP_WR_ANC  = 4'd8;

  logic [4:0]  cwp_q;
  logic        s_q, ps_q, et_q, ef_q, ec_q;
  logic [3:0]  pil_q;
  logic [31:0] mask_q;
  logic [19:0] base_q;
  logic [7:0]  tt_q;
  logic [31:0] anc_q [NANC];

  logic [31:0] op2, wr_val, stat_word, tb_word, rd_next;
  logic        priv_op, fault, bad_cwp;

  assign op2     = use_imm ? {{19{imm13[12]}}, imm13} : src2;
  assign wr_val  = src1 ^ op2;
  assign priv_op = (op >= OP_RD_STAT) && (op <= OP_WR_TB);
  assign fault   = priv_op && !priv_mode;
  assign bad_cwp = {27'd0, wr_val[4:0]} >= 32'(NWIN);

  assign stat_word = {IMPL_VER, 10'd0, ec_q, ef_q, pil_q, s_q, ps_q, et_q, cwp_q};
  assign tb_word   = {base_q, tt_q, 4'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp_q <= '0;
      s_q   <= 1'b1;
      ps_q  <= 1'b0;
      et_q  <= 1'b0;
      pil_q <= '0;
      ef_q  <= 1'b0;
      ec_q  <= 1'b0;
    end else if (op == OP_WR_STAT && !fault && !bad_cwp) begin
      cwp_q <= wr_val[4:0];
      et_q  <= wr_val[5];
      ps_q  <= wr_val[6];
      s_q   <= wr_val[7];
      pil_q <= wr_val[11:8];
      ef_q  <= wr_val[12];
      ec_q  <= wr_val[13];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (op == OP_WR_MASK && !fault) mask_q <= wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (op == OP_WR_TB && !fault) base_q <= wr_val[31:12];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tt_q <= '0;
    else if (tt_load) tt_q <= tt_code;
  end

  for (genvar g = 0; g < NANC; g++) begin : g_anc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) anc_q[g] <= '0;
      else if (op == OP_WR_ANC && anc_sel == ANC_AW'(g)) anc_q[g] <= wr_val;
    end
  end

  always_comb begin
    rd_next = rd_data;
    if (!fault) begin
      case (op)
        OP_RD_STAT: rd_next = stat_word;
        OP_RD_MASK: rd_next = mask_q & WMASK;
        OP_RD_TB:   rd_next = tb_word;
        OP_RD_ANC:  rd_next = anc_q[anc_sel];
        default:    rd_next = rd_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data      <= '0;
      trap_priv    <= 1'b0;
      trap_illegal <= 1'b0;
    end else begin
      rd_data      <= rd_next;
      trap_priv    <= fault;
      trap_illegal <= (op == OP_WR_STAT) && !fault && bad_cwp;
    end
  end

  assign cwp       = cwp_q;
  assign sup       = s_q;
  assign prev_sup  = ps_q;
  assign trap_en   = et_q;
  assign irq_level = pil_q;
  assign fpu_en    = ef_q;
  assign cop_en    = ec_q;

  p_cwp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cwp) < NWIN);

  p_bad_cwp_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WR_STAT && priv_mode && bad_cwp) |=> (trap_illegal && $stable(cwp) && $stable(irq_level)));

  p_priv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_op && !priv_mode) |=> (trap_priv && $stable(stat_word) && $stable(mask_q) && $stable(base_q) && $stable(rd_data)));

  p_mask_clip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD_MASK && priv_mode) |=> ((rd_data & ~WMASK) == 32'd0));

  p_tb_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD_TB && priv_mode) |=> (rd_data[3:0] == 4'd0));

  p_anc_notrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD_ANC || op == OP_WR_ANC) |=> !trap_priv && !trap_illegal);

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 4'd0 || op == OP_WR_STAT || op == OP_WR_MASK || op == OP_WR_TB || op == OP_WR_ANC) |=> $stable(rd_data));

endmodule

// File: tb/test_priv_ctl_regs.sv
module test_priv_ctl_regs;
  localparam int NW = 6;
  localparam logic [7:0] IV = 8'hA5;
  localparam logic [31:0] WM = 32'h0000_003F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] anc_sel = '0;
  logic [31:0] src1 = '0, src2 = '0;
  logic use_imm = 1'b0;
  logic [12:0] imm13 = '0;
  logic priv_mode = 1'b1;
  logic tt_load = 1'b0;
  logic [7:0] tt_code = '0;
  logic [31:0] rd_data;
  logic [4:0] cwp;
  logic sup, prev_sup, trap_en, fpu_en, cop_en, trap_priv, trap_illegal;
  logic [3:0] irq_level;

  priv_ctl_regs #(.NWIN(NW), .ANC_AW(2), .IMPL_VER(IV)) i_priv_ctl_regs (
    .clk(clk), .rst_n(rst_n), .op(op), .anc_sel(anc_sel), .src1(src1), .src2(src2),
    .use_imm(use_imm), .imm13(imm13), .priv_mode(priv_mode), .tt_load(tt_load),
    .tt_code(tt_code), .rd_data(rd_data), .cwp(cwp), .sup(sup), .prev_sup(prev_sup),
    .trap_en(trap_en), .irq_level(irq_level), .fpu_en(fpu_en), .cop_en(cop_en),
    .trap_priv(trap_priv), .trap_illegal(trap_illegal));

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [13:0] m_stat;
  logic [31:0] m_mask, m_rd;
  logic [19:0] m_base;
  logic [7:0]  m_tt;
  logic [31:0] m_anc [4];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp();
    return {IV, 10'd0, m_stat};
  endfunction

  function automatic logic [31:0] xv(input logic [31:0] a, b, input logic ui, input logic [12:0] im);
    return a ^ (ui ? {{19{im[12]}}, im} : b);
  endfunction

  task automatic do_op(input logic [3:0] o, input logic [1:0] sel, input logic [31:0] a, b,
                       input logic ui, input logic [12:0] im, input logic pv);
    op = o; anc_sel = sel; src1 = a; src2 = b; use_imm = ui; imm13 = im; priv_mode = pv;
    @(negedge clk);
    op = 4'd0; tt_load = 1'b0; priv_mode = 1'b1;
  endtask

  task automatic check_status_outs(input string tag);
    chk(tag, {cop_en, fpu_en, irq_level, sup, prev_sup, trap_en, cwp}, {18'd0, m_stat});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    m_stat = 14'h0080; m_mask = '0; m_base = '0; m_tt = '0; m_rd = '0;
    for (int k = 0; k < 4; k++) m_anc[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R8 rd_data reset", rd_data, 32'd0);
    check_status_outs("R8 status outputs reset");
    chk("R8 traps reset", {30'd0, trap_priv, trap_illegal}, 32'd0);
    do_op(4'd1, 0, 0, 0, 0, 0, 1);
    chk("R8 status word reset", rd_data, 32'hA500_0080);
    do_op(4'd3, 0, 0, 0, 0, 0, 1);
    chk("R8 mask reset", rd_data, 32'd0);
    do_op(4'd5, 0, 0, 0, 0, 0, 1);
    chk("R8 trap base reset", rd_data, 32'd0);
    for (int k = 0; k < 4; k++) begin
      do_op(4'd7, k[1:0], 0, 0, 0, 0, 1);
      chk("R8 ancillary reset", rd_data, 32'd0);
    end

    // R5 R6 R10: status write sweep over every cwp value
    for (int v = 0; v < 32; v++) begin
      logic [31:0] w, a, b;
      logic [12:0] im;
      logic ui;
      w  = ((32'(v) * 32'h0135_7100) & 32'hFFFF_FFE0) | 32'(v);
      ui = v[0];
      im = 13'(v * 13'h0AB3);
      b  = 32'h1234_5678 * 32'(v + 1);
      a  = w ^ (ui ? {{19{im[12]}}, im} : b);
      do_op(4'd2, 0, a, b, ui, im, 1);
      if (v < NW) m_stat = w[13:0];
      chk("R6 trap_illegal on status write", {31'd0, trap_illegal}, {31'd0, v >= NW});
      chk("R7 no trap_priv on granted write", {31'd0, trap_priv}, 32'd0);
      check_status_outs("R10 status outputs after write");
      do_op(4'd1, 0, 0, 0, 0, 0, 1);
      chk("R5 status read after write", rd_data, stat_exp());
    end

    // R1 R3: mask sweep
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a, b;
      logic [12:0] im;
      logic ui;
      a  = 32'h9E37_79B9 * 32'(i + 3);
      b  = 32'h7F4A_7C15 ^ (32'(i) << (i % 26));
      im = 13'(i * 97);
      ui = (i % 3) == 0;
      do_op(4'd4, 0, a, b, ui, im, 1);
      m_mask = xv(a, b, ui, im);
      do_op(4'd3, 0, 0, 0, 0, 0, 1);
      chk("R3 mask read clipped", rd_data, m_mask & WM);
    end

    // R4: trap base writes with and without trap-type loads
    for (int i = 0; i < 16; i++) begin
      logic [31:0] a, b;
      logic [12:0] im;
      logic ui;
      a  = 32'hC3A5_0F1E * 32'(i + 1);
      b  = 32'h0BAD_F00D + 32'(i * 4099);
      ui = i[1];
      im = 13'(13'h1FFF - 13'(i * 31));
      if (i[0]) begin tt_load = 1'b1; tt_code = 8'(i * 17 + 3); m_tt = 8'(i * 17 + 3); end
      do_op(4'd6, 0, a, b, ui, im, 1);
      m_base = xv(a, b, ui, im) >> 12;
      do_op(4'd5, 0, 0, 0, 0, 0, 1);
      chk("R4 trap base read", rd_data, {m_base, m_tt, 4'd0});
    end

    // R9 R1: ancillary registers, both privilege modes
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, b;
      logic [12:0] im;
      logic ui;
      a  = 32'h0F0F_1234 * 32'(i + 5);
      b  = 32'hDEAD_BEEF >> i;
      ui = i[2];
      im = 13'(i * 1111);
      do_op(4'd8, 2'(i), a, b, ui, im, i[0]);
      m_anc[i % 4] = xv(a, b, ui, im);
      chk("R9 no trap on ancillary write", {30'd0, trap_priv, trap_illegal}, 32'd0);
    end
    for (int k = 0; k < 4; k++) begin
      do_op(4'd7, k[1:0], 0, 0, 0, 0, k[0]);
      chk("R1 R9 ancillary read", rd_data, m_anc[k]);
      chk("R9 no trap on ancillary read", {31'd0, trap_priv}, 32'd0);
    end

    // R2: rd_data holds on idle and unused codes
    m_rd = rd_data;
    for (int c = 9; c < 16; c++) begin
      do_op(4'(c), 0, 32'hFFFF_FFFF, 0, 0, 0, 1);
      chk("R2 unused code holds rd_data", rd_data, m_rd);
    end
    do_op(4'd0, 0, 0, 0, 0, 0, 1);
    chk("R2 idle holds rd_data", rd_data, m_rd);

    // R7: privileged operations in user mode
    for (int o = 1; o <= 6; o++) begin
      m_rd = rd_data;
      do_op(4'(o), 0, 32'h5555_AAAA, 32'h0000_00C3, 0, 0, 0);
      chk("R7 trap_priv raised", {31'd0, trap_priv}, 32'd1);
      chk("R7 rd_data unchanged", rd_data, m_rd);
      check_status_outs("R7 status outputs unchanged");
    end
    do_op(4'd1, 0, 0, 0, 0, 0, 1);
    chk("R7 status unchanged", rd_data, stat_exp());
    do_op(4'd3, 0, 0, 0, 0, 0, 1);
    chk("R7 mask unchanged", rd_data, m_mask & WM);
    do_op(4'd5, 0, 0, 0, 0, 0, 1);
    chk("R7 trap base unchanged", rd_data, {m_base, m_tt, 4'd0});
    chk("R7 trap_priv clears", {31'd0, trap_priv}, 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule